// File: doc/BRIEF.md
# Interrupt Controller Register and Command Front End

This block is the byte-wide programming side of one eight-input interrupt controller. Software reaches it through three byte registers selected by a two-bit address: a command register, a data register and a trigger-mode register. Command bytes are classified by their bit pattern into an initialization start, a read/poll/mask control word, or an end-of-interrupt and rotation word. Data bytes are steered by a small sequencer through the initialization words before they reach the mask register.

The block holds the request, in-service, mask and trigger-mode registers, the vector base, the rotating priority offset and the mode flags, and drives all of them out to a separate priority resolver. The resolver returns two answers: the winning pending pin, and the highest-priority in-service pin. The block uses these answers to serve poll reads and non-specific end-of-interrupt commands. An acknowledge strobe from the resolver side moves a pin into service. Read data is registered and is valid one cycle after the read strobe.

Top module: `pic_cmd_regs`

## Requirements
- R1: After reset the request, in-service, mask, trigger-mode, vector base and priority offset registers are 0, every mode flag is clear and the sequencer is operational, so the first data-port write loads the mask.
- R2: A command write with bit 4 set starts initialization. It clears the mask, the priority offset, the special-mask flag, the read-select flag and the previous-line register. In the request register it keeps only the bits whose trigger-mode bit is 1. Bit 0 of the byte records whether a fourth word follows, and when bit 0 is 0 the nested and auto-EOI flags are cleared. The next data write is taken as word 2.
- R3: Data writes during initialization are taken in this order: word 2 sets the vector base from bits 7:3, word 3 is discarded, and word 4 (present only when it was requested) sets nested mode from bit 4 and auto-EOI from bit 1. Every later data write loads the mask.
- R4: A command write with bit 4 clear and bit 3 set is a control word. When bit 1 is set, bit 0 selects in-service (1) or request (0) as the value read from the command port. When bit 6 is set, bit 5 becomes the special-mask flag. Bit 2 arms a poll.
- R5: Any other command write is an EOI/rotation word: bits 7:5 carry the operation and bits 2:0 the pin. Code 011 clears the in-service bit of the given pin. Code 001 clears the in-service bit of the highest-priority in-service pin reported by the resolver, and does nothing when none is reported. Code 010 changes nothing.
- R6: Codes 101, 111 and 110 load the priority offset with (pin+1) mod 8, where 101 takes the pin it clears from the resolver. Code 100 sets and code 000 clears the rotate-on-auto-EOI flag. While that flag and auto-EOI are both set, an acknowledge loads the offset with (acknowledged pin+1) mod 8.
- R7: A read of the command or data port while a poll is armed returns the resolver's winning pin and clears that pin's request and in-service bits, or returns 7 when nothing is pending. The poll is then disarmed.
- R8: A request bit with trigger-mode bit 1 follows its input line. One with trigger-mode bit 0 is set on a low-to-high line transition and stays set. An acknowledge sets the pin's in-service bit (left clear under auto-EOI) and clears its request bit if that pin is edge-triggered.
- R9: A data-port read without a poll returns the mask, and a trigger-mode read returns that register, which is written directly. Address 3 ignores writes and reads 0. Read data appears with rd_valid one cycle after rd_en.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 2 | 0 command, 1 data, 2 trigger mode, 3 unmapped |
| wr_data | input | 8 | Write byte |
| rd_data | output | 8 | Registered read byte |
| rd_valid | output | 1 | rd_data valid |
| irq_lines | input | 8 | Interrupt request lines |
| ack_en | input | 1 | Acknowledge strobe |
| ack_pin | input | 3 | Pin being acknowledged |
| pend_valid | input | 1 | Resolver has a winning pending pin |
| pend_pin | input | 3 | Winning pending pin |
| isr_hi_valid | input | 1 | Resolver has an in-service pin |
| isr_hi_pin | input | 3 | Highest-priority in-service pin |
| irr | output | 8 | Request register |
| isr | output | 8 | In-service register |
| imr | output | 8 | Mask register |
| elcr | output | 8 | Trigger-mode register, 1 = level |
| vec_base | output | 5 | Vector base, upper five vector bits |
| prio_ofs | output | 3 | Rotating priority offset |
| nested_en | output | 1 | Special fully nested mode |
| auto_eoi_en | output | 1 | Auto end-of-interrupt |
| special_mask_en | output | 1 | Special-mask flag |

## Verification
The bench steers the sequencer down both initialization paths. A design that always waits for word 4 would take the first mask write as mode bits, and one that never waits for it would load the mode byte into the mask. It checks that initialization keeps only level-triggered requests, so a design that clears the whole request register, or keeps edge requests, shows a wrong value. It compares a specific EOI for a pin that is not in service against one for the pin that is, gives a non-specific EOI with no in-service pin reported, and checks the (pin+1) mod 8 offset of each rotating form, so an off-by-one or a wrong opcode decode changes the observed registers. Poll reads are taken with and without a pending pin and then repeated, so a poll that is never disarmed, or that returns the wrong fallback code, shows up on the read data.

// File: rtl/pic_cmd_pkg.sv
package pic_cmd_pkg;

  localparam int unsigned DATA_W = 8;
  localparam int unsigned NUM_LINES = 8;
  localparam int unsigned PIN_W = $clog2(NUM_LINES);
  localparam int unsigned BASE_W = DATA_W - PIN_W;
  localparam int unsigned ADDR_W = 2;

  localparam logic [ADDR_W-1:0] ADDR_CMD  = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_DATA = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_TRIG = 2'd2;

  localparam logic [DATA_W-1:0] POLL_NONE = 8'd7;

  typedef enum logic [1:0] {
    SEQ_RUN = 2'd0,
    SEQ_W2  = 2'd1,
    SEQ_W3  = 2'd2,
    SEQ_W4  = 2'd3
  } seq_e;

  typedef enum logic [2:0] {
    OP_ROT_CLR    = 3'd0,
    OP_EOI_NS     = 3'd1,
    OP_NOP        = 3'd2,
    OP_EOI_SP     = 3'd3,
    OP_ROT_SET    = 3'd4,
    OP_EOI_NS_ROT = 3'd5,
    OP_SET_PRIO   = 3'd6,
    OP_EOI_SP_ROT = 3'd7
  } op2_e;

  typedef struct packed {
    logic             is_init;
    logic             is_ctl;
    logic             is_eoi;
    op2_e             op;
    logic [PIN_W-1:0] pin;
  } cmd_t;

  function automatic cmd_t classify(input logic [DATA_W-1:0] b);
    cmd_t c;
    c.is_init = b[4];
    c.is_ctl  = !b[4] && b[3];
    c.is_eoi  = !b[4] && !b[3];
    c.op      = op2_e'(b[7:5]);
    c.pin     = b[PIN_W-1:0];
    return c;
  endfunction

  function automatic logic [PIN_W-1:0] after_pin(input logic [PIN_W-1:0] p);
    return p + 1'b1;
  endfunction

endpackage

// File: rtl/pic_cmd_decode.sv
module pic_cmd_decode
  import pic_cmd_pkg::*;
(
  input  logic [DATA_W-1:0] byte_in,
  output cmd_t              cmd
);
  always_comb cmd = classify(byte_in);
endmodule

// File: rtl/pic_init_seq.sv
module pic_init_seq
  import pic_cmd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic init_start,
  input  logic want_w4,
  input  logic data_wr,
  output seq_e state,
  output logic take_base,
  output logic take_mode,
  output logic take_mask
);
  seq_e state_q;
  logic need4_q;

  assign state     = state_q;
  assign take_base = data_wr && !init_start && state_q == SEQ_W2;
  assign take_mode = data_wr && !init_start && state_q == SEQ_W4;
  assign take_mask = data_wr && !init_start && state_q == SEQ_RUN;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_RUN;
      need4_q <= 1'b0;
    end else if (init_start) begin
      state_q <= SEQ_W2;
      need4_q <= want_w4;
    end else if (data_wr) begin
      unique case (state_q)
        SEQ_W2:  state_q <= SEQ_W3;
        SEQ_W3:  state_q <= need4_q ? SEQ_W4 : SEQ_RUN;
        SEQ_W4:  state_q <= SEQ_RUN;
        default: state_q <= SEQ_RUN;
      endcase
    end
  end

  p_seq_w2_r2: assert property (@(posedge clk) disable iff (!rst_n)
    init_start |=> state_q == SEQ_W2);
  p_skip_w4_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && !init_start && state_q == SEQ_W3 && !need4_q) |=> state_q == SEQ_RUN);
  p_one_take_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({take_base, take_mode, take_mask}) <= 1);
endmodule

// File: rtl/pic_cmd_regs.sv
module pic_cmd_regs
  import pic_cmd_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic                 rd_en,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [DATA_W-1:0]    wr_data,
  output logic [DATA_W-1:0]    rd_data,
  output logic                 rd_valid,
  input  logic [NUM_LINES-1:0] irq_lines,
  input  logic                 ack_en,
  input  logic [PIN_W-1:0]     ack_pin,
  input  logic                 pend_valid,
  input  logic [PIN_W-1:0]     pend_pin,
  input  logic                 isr_hi_valid,
  input  logic [PIN_W-1:0]     isr_hi_pin,
  output logic [NUM_LINES-1:0] irr,
  output logic [NUM_LINES-1:0] isr,
  output logic [NUM_LINES-1:0] imr,
  output logic [NUM_LINES-1:0] elcr,
  output logic [BASE_W-1:0]    vec_base,
  output logic [PIN_W-1:0]     prio_ofs,
  output logic                 nested_en,
  output logic                 auto_eoi_en,
  output logic                 special_mask_en
);
  cmd_t cmd;
  seq_e seq_state;
  logic take_base, take_mode, take_mask;

  logic [NUM_LINES-1:0] irr_q, isr_q, imr_q, elcr_q, prev_q;
  logic [NUM_LINES-1:0] irr_n, isr_n, prev_n;
  logic [BASE_W-1:0]    base_q;
  logic [PIN_W-1:0]     prio_q, prio_n;
  logic nested_q, aeoi_q, smask_q, rsel_q, poll_q, rot_q;
  logic [DATA_W-1:0] rd_val, rd_q;
  logic rd_valid_q;

  // named events
  logic wr_cmd, wr_dat, wr_trig, init_go, ctl_go, eoi_go, rd_poll;
  assign wr_cmd  = wr_en && addr == ADDR_CMD;
  assign wr_dat  = wr_en && addr == ADDR_DATA;
  assign wr_trig = wr_en && addr == ADDR_TRIG;
  assign init_go = wr_cmd && cmd.is_init;
  assign ctl_go  = wr_cmd && cmd.is_ctl;
  assign eoi_go  = wr_cmd && cmd.is_eoi;
  assign rd_poll = rd_en && poll_q && (addr == ADDR_CMD || addr == ADDR_DATA);

  pic_cmd_decode u_dec (.byte_in(wr_data), .cmd(cmd));

  pic_init_seq u_seq (
    .clk(clk), .rst_n(rst_n), .init_start(init_go), .want_w4(wr_data[0]),
    .data_wr(wr_dat), .state(seq_state), .take_base(take_base),
    .take_mode(take_mode), .take_mask(take_mask)
  );

  always_comb begin
    irr_n  = irr_q;
    isr_n  = isr_q;
    prio_n = prio_q;
    prev_n = irq_lines;
    for (int i = 0; i < NUM_LINES; i++) begin
      if (elcr_q[i]) irr_n[i] = irq_lines[i];
      else if (irq_lines[i] && !prev_q[i]) irr_n[i] = 1'b1;
    end
    if (ack_en) begin
      isr_n[ack_pin] = !aeoi_q;
      if (!elcr_q[ack_pin]) irr_n[ack_pin] = 1'b0;
      if (aeoi_q && rot_q) prio_n = after_pin(ack_pin);
    end
    if (eoi_go) begin
      unique case (cmd.op)
        OP_EOI_NS:     if (isr_hi_valid) isr_n[isr_hi_pin] = 1'b0;
        OP_EOI_NS_ROT: if (isr_hi_valid) begin
                         isr_n[isr_hi_pin] = 1'b0;
                         prio_n = after_pin(isr_hi_pin);
                       end
        OP_EOI_SP:     isr_n[cmd.pin] = 1'b0;
        OP_EOI_SP_ROT: begin
                         isr_n[cmd.pin] = 1'b0;
                         prio_n = after_pin(cmd.pin);
                       end
        OP_SET_PRIO:   prio_n = after_pin(cmd.pin);
        default: ;
      endcase
    end
    if (rd_poll && pend_valid) begin
      irr_n[pend_pin] = 1'b0;
      isr_n[pend_pin] = 1'b0;
    end
    if (init_go) begin
      irr_n  = irr_q & elcr_q;
      prev_n = '0;
      prio_n = '0;
    end
  end

  always_comb begin
    if (rd_poll) rd_val = pend_valid ? DATA_W'(pend_pin) : POLL_NONE;
    else begin
      unique case (addr)
        ADDR_CMD:  rd_val = rsel_q ? isr_q : irr_q;
        ADDR_DATA: rd_val = imr_q;
        ADDR_TRIG: rd_val = elcr_q;
        default:   rd_val = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irr_q <= '0; isr_q <= '0; imr_q <= '0; elcr_q <= '0; prev_q <= '0;
      base_q <= '0; prio_q <= '0;
      nested_q <= 1'b0; aeoi_q <= 1'b0; smask_q <= 1'b0; rsel_q <= 1'b0;
      poll_q <= 1'b0; rot_q <= 1'b0;
      rd_q <= '0; rd_valid_q <= 1'b0;
    end else begin
      irr_q  <= irr_n;
      isr_q  <= isr_n;
      prev_q <= prev_n;
      prio_q <= prio_n;
      rd_valid_q <= rd_en;
      if (rd_en) rd_q <= rd_val;
      if (wr_trig) elcr_q <= wr_data;
      if (rd_poll) poll_q <= 1'b0;
      if (init_go) begin
        imr_q   <= '0;
        smask_q <= 1'b0;
        rsel_q  <= 1'b0;
        if (!wr_data[0]) begin
          nested_q <= 1'b0;
          aeoi_q   <= 1'b0;
        end
      end
      if (take_base) base_q <= wr_data[DATA_W-1:PIN_W];
      if (take_mode) begin
        nested_q <= wr_data[4];
        aeoi_q   <= wr_data[1];
      end
      if (take_mask) imr_q <= wr_data;
      if (ctl_go) begin
        if (wr_data[2]) poll_q <= 1'b1;
        if (wr_data[1]) rsel_q <= wr_data[0];
        if (wr_data[6]) smask_q <= wr_data[5];
      end
      if (eoi_go && cmd.op == OP_ROT_SET) rot_q <= 1'b1;
      if (eoi_go && cmd.op == OP_ROT_CLR) rot_q <= 1'b0;
    end
  end

  assign irr = irr_q;
  assign isr = isr_q;
  assign imr = imr_q;
  assign elcr = elcr_q;
  assign vec_base = base_q;
  assign prio_ofs = prio_q;
  assign nested_en = nested_q;
  assign auto_eoi_en = aeoi_q;
  assign special_mask_en = smask_q;
  assign rd_data = rd_q;
  assign rd_valid = rd_valid_q;

  p_init_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    init_go |=> (imr_q == '0 && prio_q == '0 && !smask_q && !rsel_q));
  p_spec_eoi_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_go && cmd.op == OP_EOI_SP && !ack_en) |=> !isr_q[$past(wr_data[PIN_W-1:0])]);
  p_prio_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_go && (cmd.op == OP_SET_PRIO || cmd.op == OP_EOI_SP_ROT))
      |=> prio_q == $past(wr_data[PIN_W-1:0]) + 1'b1);
  p_poll_disarm_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_poll && !(ctl_go && wr_data[2])) |=> !poll_q);
  p_ack_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_en && !aeoi_q && !eoi_go && !rd_poll && !init_go) |=> isr_q[$past(ack_pin)]);
  p_rd_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);
  p_unmapped_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 2'd3) |=> ($stable(imr_q) && $stable(elcr_q) && $stable(base_q)));
endmodule

// File: tb/pic_cmd_regs_bench.sv
module pic_cmd_regs_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 0, rd_en = 0, ack_en = 0, pend_valid = 0, isr_hi_valid = 0;
  logic [1:0] addr = 0;
  logic [7:0] wr_data = 0, irq_lines = 0;
  logic [2:0] ack_pin = 0, pend_pin = 0, isr_hi_pin = 0;
  logic [7:0] rd_data, irr, isr, imr, elcr;
  logic rd_valid, nested_en, auto_eoi_en, special_mask_en;
  logic [4:0] vec_base;
  logic [2:0] prio_ofs;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [7:0] exp_q[$];
  string tag_q[$];

  always #10 clk = ~clk;

  pic_cmd_regs u_pic_cmd_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .rd_valid(rd_valid),
    .irq_lines(irq_lines), .ack_en(ack_en), .ack_pin(ack_pin),
    .pend_valid(pend_valid), .pend_pin(pend_pin),
    .isr_hi_valid(isr_hi_valid), .isr_hi_pin(isr_hi_pin),
    .irr(irr), .isr(isr), .imr(imr), .elcr(elcr), .vec_base(vec_base),
    .prio_ofs(prio_ofs), .nested_en(nested_en), .auto_eoi_en(auto_eoi_en),
    .special_mask_en(special_mask_en)
  );

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1; addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [7:0] exp, input string tag);
    exp_q.push_back(exp); tag_q.push_back(tag);
    rd_en = 1; addr = a;
    @(negedge clk);
    rd_en = 0;
    @(negedge clk);
  endtask

  task automatic ack(input logic [2:0] p);
    ack_en = 1; ack_pin = p;
    @(negedge clk);
    ack_en = 0;
  endtask

  task automatic lines(input logic [7:0] v);
    irq_lines = v;
    @(negedge clk);
  endtask

  // monitor: pop expected read data as the design produces it
  always @(negedge clk) begin
    if (rd_valid) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R9 actual=%h expected=none", rd_data);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front(); t = tag_q.pop_front();
        chk(rd_data, e, t);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(irr, 0, "R1 irr"); chk(isr, 0, "R1 isr"); chk(imr, 0, "R1 imr");
    chk(elcr, 0, "R1 elcr"); chk({3'b0, vec_base}, 0, "R1 base");
    chk({5'b0, prio_ofs}, 0, "R1 prio");
    chk({5'b0, nested_en, auto_eoi_en, special_mask_en}, 0, "R1 flags");
    chk({7'b0, rd_valid}, 0, "R1 rd_valid");
    wr(2'd1, 8'h5A);
    chk(imr, 8'h5A, "R1 first data write is mask");
    rd(2'd1, 8'h5A, "R9 mask read");
    // R9 trigger register and unmapped address
    wr(2'd2, 8'h10);
    rd(2'd2, 8'h10, "R9 trigger read");
    wr(2'd3, 8'hFF);
    chk(imr, 8'h5A, "R9 unmapped write imr"); chk(elcr, 8'h10, "R9 unmapped write elcr");
    rd(2'd3, 8'h00, "R9 unmapped read");
    // R8 edge vs level sampling
    lines(8'h30); chk(irr, 8'h30, "R8 both set");
    lines(8'h00); chk(irr, 8'h20, "R8 level follows, edge holds");
    lines(8'h10); chk(irr, 8'h30, "R8 level again");
    // R2 init with word 4
    wr(2'd0, 8'h11);
    chk(imr, 0, "R2 mask cleared"); chk(irr, 8'h10, "R2 only level kept");
    wr(2'd1, 8'h70); chk({3'b0, vec_base}, 8'h0E, "R3 base from word 2");
    wr(2'd1, 8'hFF); chk(imr, 0, "R3 word 3 ignored");
    wr(2'd1, 8'h13); chk({6'b0, nested_en, auto_eoi_en}, 8'h03, "R3 word 4 flags");
    chk(imr, 0, "R3 word 4 not mask");
    wr(2'd1, 8'h04); chk(imr, 8'h04, "R3 mask after sequence");
    // R2/R3 init without word 4
    wr(2'd0, 8'h10);
    chk({6'b0, nested_en, auto_eoi_en}, 0, "R2 flags cleared without word 4");
    wr(2'd1, 8'h08); chk({3'b0, vec_base}, 8'h01, "R3 base");
    wr(2'd1, 8'hFF);
    wr(2'd1, 8'h12); chk(imr, 8'h12, "R3 word 4 skipped");
    chk({7'b0, nested_en}, 0, "R3 skipped word not mode");
    wr(2'd1, 8'h00);
    lines(8'h00);
    // R8 acknowledge
    lines(8'h08); lines(8'h00);
    chk(irr, 8'h08, "R8 edge latched");
    ack(3'd3);
    chk(isr, 8'h08, "R8 ack sets isr"); chk(irr, 0, "R8 ack clears edge request");
    // R4 read select and special mask
    rd(2'd0, 8'h00, "R4 default reads irr");
    wr(2'd0, 8'h0B); rd(2'd0, 8'h08, "R4 select isr");
    wr(2'd0, 8'h0A); rd(2'd0, 8'h00, "R4 select irr");
    wr(2'd0, 8'h68); chk({7'b0, special_mask_en}, 1, "R4 special mask set");
    wr(2'd0, 8'h28); chk({7'b0, special_mask_en}, 1, "R4 bit6 clear keeps flag");
    wr(2'd0, 8'h48); chk({7'b0, special_mask_en}, 0, "R4 special mask clear");
    // R5 specific EOI
    wr(2'd0, 8'h64); chk(isr, 8'h08, "R5 specific EOI other pin");
    wr(2'd0, 8'h63); chk(isr, 8'h00, "R5 specific EOI");
    // R5 non-specific EOI
    ack(3'd1); ack(3'd6); chk(isr, 8'h42, "R8 two in service");
    isr_hi_valid = 1; isr_hi_pin = 3'd1;
    wr(2'd0, 8'h20); chk(isr, 8'h40, "R5 non-specific EOI");
    isr_hi_valid = 0;
    wr(2'd0, 8'h20); chk(isr, 8'h40, "R5 non-specific EOI with none reported");
    // R6 rotating non-specific
    isr_hi_valid = 1; isr_hi_pin = 3'd6;
    wr(2'd0, 8'hA0); chk(isr, 0, "R6 rotating NS clears");
    chk({5'b0, prio_ofs}, 8'd7, "R6 rotating NS offset");
    isr_hi_valid = 0;
    wr(2'd0, 8'hC2); chk({5'b0, prio_ofs}, 8'd3, "R6 set priority");
    ack(3'd5);
    wr(2'd0, 8'hE5); chk(isr, 0, "R6 rotating specific clears");
    chk({5'b0, prio_ofs}, 8'd6, "R6 rotating specific offset");
    wr(2'd0, 8'hC7); chk({5'b0, prio_ofs}, 8'd0, "R6 offset wraps");
    ack(3'd2);
    wr(2'd0, 8'h42); chk(isr, 8'h04, "R5 no-op isr"); chk({5'b0, prio_ofs}, 0, "R5 no-op offset");
    wr(2'd0, 8'h62);
    // R6 rotate on auto-EOI
    wr(2'd0, 8'h11); wr(2'd1, 8'h08); wr(2'd1, 8'hFF); wr(2'd1, 8'h02);
    chk({7'b0, auto_eoi_en}, 1, "R3 auto-EOI set");
    wr(2'd0, 8'h80);
    ack(3'd4);
    chk(isr, 0, "R8 auto-EOI leaves isr clear"); chk({5'b0, prio_ofs}, 8'd5, "R6 auto rotate");
    wr(2'd0, 8'h00);
    ack(3'd2); chk({5'b0, prio_ofs}, 8'd5, "R6 rotate cleared");
    // R7 poll
    lines(8'h40); lines(8'h00);
    pend_valid = 1; pend_pin = 3'd6;
    wr(2'd0, 8'h0C);
    rd(2'd1, 8'h06, "R7 poll pin");
    chk(irr, 0, "R7 poll clears request");
    rd(2'd1, 8'h00, "R7 poll disarmed data read");
    pend_valid = 0;
    wr(2'd0, 8'h0C);
    rd(2'd0, 8'h07, "R7 poll none pending");
    rd(2'd0, 8'h00, "R7 poll disarmed command read");
    repeat (2) @(negedge clk);
    chk(8'(exp_q.size()), 0, "R9 all reads returned");
    finish_run();
  end
endmodule